// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the bit-rate timing strobe for a UART transmitter and receiver pair. Two reference sources reach it as single-cycle enable strobes in the block's own clock domain: a crystal reference and a system-bus reference. A 32-bit configuration word chooses which reference feeds the divider chain, how that reference is pre-scaled, and the value of a 23-bit programmable divider. The result is a one-cycle `baud_tick` pulse at the programmed rate. Software loads the divider with the selected source rate divided by the wanted baud rate, minus one, rounded to the nearest integer.

The source selection has two levels. One bit chooses between the crystal path and the system path. On the crystal path, a two-bit code picks the pre-scale ratio. A build-time variant parameter selects between the current layout and a legacy layout. The legacy layout has no storage for the crystal ratio code, so its crystal path always divides by three. It is also the only layout with a divide-by-four stage on the system reference. In the current layout the system strobes pass straight through.

All counters advance only on their input strobes. No derived clock is created, so the whole chain stays in one clock domain.

Top module: `uart_baud_gen`

## Requirements
- R1: With the enable bit (bit 23) set, `baud_tick` pulses once every (D+1) strobes of the selected pre-scaled source, where D is bits 22:0. Each pulse falls in the same cycle as the strobe that completes the period.
- R2: While bit 23 reads 0, `baud_tick` stays low and all counters are held at zero. Setting bit 23 again without changing any other field starts a full period from zero.
- R3: Bit 24 at 1 selects the crystal path and bit 24 at 0 selects the system path. The system path divides `sys_stb` by 4 in the legacy variant and passes it through unchanged otherwise.
- R4: In the current variant, bits 27:26 set the crystal pre-scale: 00 gives ÷3, 01 gives ÷1, 10 gives ÷2 and 11 gives ÷2.
- R5: In the legacy variant (LEGACY=1), bits 27:26 are not stored and always read 0, and the crystal path is a fixed ÷3.
- R6: A divider value of 0 makes `baud_tick` follow every strobe of the selected pre-scaled source.
- R7: A write that changes any stored bit among 27:24 or 22:0 clears every counter at that clock edge. Any source strobe in that same cycle is discarded. The first tick then arrives after exactly one full new period.
- R8: A write that leaves the stored bits 27:24 and 22:0 unchanged does not disturb the tick phase. This covers an identical rewrite and a change only to unimplemented bits.
- R9: A synchronous active-low reset clears the configuration and all counters. After reset, `cfg_rdata` reads 0 and no ticks are produced.
- R10: `cfg_rdata` returns the stored fields, and every unimplemented bit reads 0. Bits 31:28 and 25 always read 0, as do bits 27:26 in the legacy variant. The readable mask is 0x0DFFFFFF for the current variant and 0x01FFFFFF for the legacy variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Writes `cfg_wdata` into the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration fields, with unimplemented bits read as 0 |
| xtal_stb | input | 1 | Crystal reference strobe |
| sys_stb | input | 1 | System-bus reference strobe |
| baud_tick | output | 1 | One-cycle baud rate tick |

## Verification
The following properties are checked on every cycle:
- No tick appears while the enable bit reads 0.
- Every tick coincides with a strobe on the selected source.
- Every counter stays inside the bound set by its ratio or divider.
- A restart or disable always leaves the counters at zero on the next cycle.
- A write always lands in the readable fields under the variant's mask.

The exact tick spacing for each source, ratio code and divider value can only be shown by the bench's sweeps, which count strobes against the expected period. The same holds for the retained phase across non-restarting writes and for the discarded strobe in a restart cycle.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    // Field positions that software relies on
    localparam int BIT_EN   = 23;
    localparam int BIT_SRC  = 24;
    localparam int BIT_XSEL = 26;

    // Pre-scaler counter and ratio widths (ratios up to 4)
    localparam int PRE_CW = 2;
    localparam int PRE_RW = PRE_CW + 1;

    localparam logic [PRE_RW-1:0] LEGACY_XTAL_RATIO = PRE_RW'(3);
    localparam logic [PRE_RW-1:0] LEGACY_SYS_RATIO  = PRE_RW'(4);

    // Crystal pre-scale ratio decoded from the two-bit code
    function automatic logic [PRE_RW-1:0] xtal_ratio(input logic [1:0] code);
        logic [PRE_RW-1:0] r;
        case (code)
            2'b00:   r = PRE_RW'(3);
            2'b01:   r = PRE_RW'(1);
            default: r = PRE_RW'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_baud_cfg.sv
module uart_baud_cfg
    import uart_baud_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    parameter int DIV_W  = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic [DIV_W-1:0] div_val,
    output logic             en,
    output logic             src_xtal,
    output logic [1:0]       xsel,
    output logic             restart
);

    localparam logic [31:0] DIV_MASK = 32'((64'd1 << DIV_W) - 64'd1);
    localparam logic [31:0] RD_MASK  = DIV_MASK | (32'd1 << BIT_EN) | (32'd1 << BIT_SRC)
                                     | (LEGACY ? 32'd0 : (32'd3 << BIT_XSEL));

    typedef struct packed {
        logic [1:0]       xsel;
        logic             src;
        logic             en;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t st_d, st_q, wr_v;
    logic restart_c;
    logic unused_wr;

    assign unused_wr = ^cfg_wdata[31:DIV_W];

    always_comb begin
        wr_v.div  = cfg_wdata[DIV_W-1:0];
        wr_v.en   = cfg_wdata[BIT_EN];
        wr_v.src  = cfg_wdata[BIT_SRC];
        wr_v.xsel = LEGACY ? 2'b00 : cfg_wdata[BIT_XSEL+1:BIT_XSEL];
        st_d      = st_q;
        restart_c = 1'b0;
        if (cfg_wr) begin
            st_d      = wr_v;
            restart_c = (wr_v.div != st_q.div) || (wr_v.src != st_q.src)
                     || (wr_v.xsel != st_q.xsel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata                         = '0;
        cfg_rdata[DIV_W-1:0]              = st_q.div;
        cfg_rdata[BIT_EN]                 = st_q.en;
        cfg_rdata[BIT_SRC]                = st_q.src;
        cfg_rdata[BIT_XSEL+1:BIT_XSEL]    = st_q.xsel;
    end

    assign div_val  = st_q.div;
    assign en       = st_q.en;
    assign src_xtal = st_q.src;
    assign xsel     = st_q.xsel;
    assign restart  = restart_c;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & RD_MASK)); // R10

endmodule

// File: rtl/uart_baud_prediv.sv
module uart_baud_prediv
    import uart_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PRE_RW-1:0] ratio,
    input  logic              in_stb,
    output logic              out_stb
);

    typedef struct packed {
        logic [PRE_CW-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic out_c;

    always_comb begin
        st_d  = st_q;
        out_c = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (in_stb) begin
            if ({1'b0, st_q.cnt} == (ratio - 1'b1)) begin
                out_c    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_stb = out_c;

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.cnt} < ratio); // R4
    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0); // R7

endmodule

// File: rtl/uart_baud_main_div.sv
module uart_baud_main_div #(
    parameter int DIV_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             src_stb,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } main_t;

    main_t st_d, st_q;
    logic  tick_c;

    always_comb begin
        st_d   = st_q;
        tick_c = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (src_stb) begin
            if (st_q.cnt == div_val) begin
                tick_c   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = tick_c;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= div_val); // R1
    AST_MAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0); // R7

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    parameter int DIV_W  = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        xtal_stb,
    input  logic        sys_stb,
    output logic        baud_tick
);

    logic [DIV_W-1:0]  div_val;
    logic              en;
    logic              src_xtal;
    logic [1:0]        xsel;
    logic              restart;
    logic              clr;
    logic [PRE_RW-1:0] xratio;
    logic              xtal_path;
    logic              sys_path;
    logic              src_path;

    uart_baud_cfg #(.LEGACY(LEGACY), .DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .div_val   (div_val),
        .en        (en),
        .src_xtal  (src_xtal),
        .xsel      (xsel),
        .restart   (restart)
    );

    // Counters restart on a field change and are held while disabled
    assign clr    = restart | ~en;
    assign xratio = LEGACY ? LEGACY_XTAL_RATIO : xtal_ratio(xsel);

    uart_baud_prediv u_xtal_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ratio   (xratio),
        .in_stb  (xtal_stb),
        .out_stb (xtal_path)
    );

    generate
        if (LEGACY) begin : g_sys_div4
            uart_baud_prediv u_sys_pre (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .ratio   (LEGACY_SYS_RATIO),
                .in_stb  (sys_stb),
                .out_stb (sys_path)
            );
        end else begin : g_sys_direct
            assign sys_path = sys_stb;
        end
    endgenerate

    assign src_path = src_xtal ? xtal_path : sys_path;

    uart_baud_main_div #(.DIV_W(DIV_W)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .div_val (div_val),
        .src_stb (src_path),
        .tick    (baud_tick)
    );

    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[BIT_EN] |-> !baud_tick); // R2
    AST_TICK_ON_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (cfg_rdata[BIT_SRC] ? xtal_stb : sys_stb)); // R3

endmodule

// File: tb/test_uart_baud_gen.sv
`timescale 1ns/1ps
module test_uart_baud_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_a = 1'b0, wr_b = 1'b0;
    logic [31:0] wd_a = '0, wd_b = '0;
    logic [31:0] rd_a, rd_b;
    logic        xtal_stb = 1'b0, sys_stb = 1'b0;
    logic        tick_a, tick_b;

    int checks = 0;
    int errors = 0;
    int kx = 1, ks = 1;
    int cyc = 0;

    // Per-variant model state: index 0 current, 1 legacy
    int          n_stb [2];
    logic [31:0] prev  [2];
    int          mm    [2];
    int          f_cyc [2];
    logic        f_exp [2];
    logic        f_act [2];

    always #2.5 clk = ~clk;

    uart_baud_gen #(.LEGACY(1'b0), .DIV_W(23)) i_uart_baud_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr_a), .cfg_wdata(wd_a), .cfg_rdata(rd_a),
        .xtal_stb(xtal_stb), .sys_stb(sys_stb), .baud_tick(tick_a)
    );

    uart_baud_gen #(.LEGACY(1'b1), .DIV_W(23)) i_uart_baud_gen_legacy (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr_b), .cfg_wdata(wd_b), .cfg_rdata(rd_b),
        .xtal_stb(xtal_stb), .sys_stb(sys_stb), .baud_tick(tick_b)
    );

    // Period in raw source strobes, from R1, R3, R4, R5
    function automatic int period(input int k, input logic [31:0] v);
        int pre;
        if (v[24]) begin
            if (k == 1)              pre = 3;
            else if (v[27:26] == 0)  pre = 3;
            else if (v[27:26] == 1)  pre = 1;
            else                     pre = 2;
        end else begin
            pre = (k == 1) ? 4 : 1;
        end
        return pre * (int'(v[22:0]) + 1);
    endfunction

    task automatic step(input int k, input bit w, input logic [31:0] v, input logic act);
        logic [31:0] mask;
        logic        stb;
        logic        e;
        mask = (k == 1) ? 32'h017F_FFFF : 32'h0D7F_FFFF;
        stb  = prev[k][24] ? xtal_stb : sys_stb;
        if (w && (((v ^ prev[k]) & mask) != 0)) begin
            n_stb[k] = 0;   // R7: restart, strobe discarded
            e = 1'b0;
        end else if (prev[k][23]) begin
            if (stb) n_stb[k]++;
            e = stb && ((n_stb[k] % period(k, prev[k])) == 0);
        end else begin
            n_stb[k] = 0;   // R2: held while disabled
            e = 1'b0;
        end
        if (act !== e) begin
            if (mm[k] == 0) begin
                f_cyc[k] = cyc; f_exp[k] = e; f_act[k] = act;
            end
            mm[k]++;
        end
        if (w) prev[k] = v;
    endtask

    task automatic cycle(input bit wa, input logic [31:0] va, input bit wb,
                         input logic [31:0] vb, input logic sx, input logic ss);
        @(negedge clk);
        wr_a = wa; wd_a = va; wr_b = wb; wd_b = vb;
        xtal_stb = sx; sys_stb = ss;
        #1;
        step(0, wa, va, tick_a);
        step(1, wb, vb, tick_b);
    endtask

    task automatic check_mm(input string tag);
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (mm[k] != 0) begin
                errors++;
                $display("FAIL %s (%s variant): %0d tick mismatches, first at cycle %0d actual %b expected %b",
                         tag, (k == 1) ? "legacy" : "current", mm[k], f_cyc[k], f_act[k], f_exp[k]);
            end
            mm[k] = 0;
        end
    endtask

    task automatic run(input int ncyc, input string tag);
        for (int i = 0; i < ncyc; i++) begin
            cyc++;
            cycle(1'b0, 32'h0, 1'b0, 32'h0, (cyc % kx) == 0, (cyc % ks) == 0);
        end
        check_mm(tag);
    endtask

    task automatic wr(input int k, input logic [31:0] v, input logic stb);
        cyc++;
        cycle(k == 0, v, k == 1, v, stb, stb);
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        logic [31:0] v;
        int          bad;
        for (int k = 0; k < 2; k++) begin
            n_stb[k] = 0; prev[k] = '0; mm[k] = 0; f_cyc[k] = 0; f_exp[k] = 0; f_act[k] = 0;
        end

        // R9: reset state with strobes active
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            xtal_stb = 1'b1; sys_stb = 1'b1;
            #1;
            if (tick_a !== 1'b0 || tick_b !== 1'b0) bad++;
        end
        @(negedge clk);
        xtal_stb = 1'b0; sys_stb = 1'b0; rst_n = 1'b1;
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R9 reset: ticks during reset actual %0d expected 0", bad);
        end
        #1;
        check32("R9 reset readback current", rd_a, 32'h0);
        check32("R9 reset readback legacy", rd_b, 32'h0);
        kx = 1; ks = 1;
        run(20, "R9 no ticks after reset");

        // R10, R5: readback masks
        wr(0, 32'hFFFF_FFFF, 1'b0);
        wr(1, 32'hFFFF_FFFF, 1'b0);
        run(2, "R10 readback phase");
        check32("R10 readback current", rd_a, 32'h0DFF_FFFF);
        check32("R5 readback legacy", rd_b, 32'h01FF_FFFF);
        wr(0, 32'h0800_0000, 1'b0);
        wr(1, 32'h0800_0000, 1'b0);
        run(2, "R10 readback phase");
        check32("R10 ratio code stored", rd_a, 32'h0800_0000);
        check32("R5 ratio code not stored", rd_b, 32'h0000_0000);

        // R1 R3 R4 R5 R6: sweep of source, ratio code and divider
        for (int src = 0; src < 2; src++) begin
            for (int xs = 0; xs < 4; xs++) begin
                for (int di = 0; di < 4; di++) begin
                    v = (32'd1 << 23) | (32'(src) << 24) | (32'(xs) << 26)
                      | ((di == 3) ? 32'd5 : 32'(di));
                    kx = 1 + ((xs + di) % 3);
                    ks = 1 + ((di + src) % 2);
                    wr(0, v, 1'b0);
                    wr(1, v, 1'b0);
                    run(120, "R1/R3/R4/R5/R6 sweep");
                end
            end
        end

        // R2: disabled produces nothing, re-enable starts from zero
        kx = 1; ks = 1;
        wr(0, 32'h0100_0002, 1'b0);
        wr(1, 32'h0100_0002, 1'b0);
        run(60, "R2 disabled");
        wr(0, 32'h0180_0002, 1'b0);
        wr(1, 32'h0180_0002, 1'b0);
        run(80, "R2 re-enable");

        // R8: writes that keep the fields do not disturb phase
        v = 32'h0980_0003;
        wr(0, v, 1'b0);
        wr(1, v, 1'b0);
        run(13, "R8 setup");
        wr(0, v, 1'b0);
        wr(1, v, 1'b0);
        run(5, "R8 identical rewrite");
        wr(0, v | 32'h0200_0000, 1'b0);
        wr(1, v | 32'h0C00_0000, 1'b0);
        run(80, "R8 unimplemented bits");

        // R7: mid-period change with a strobe in the write cycle
        kx = 2; ks = 1;
        run(7, "R7 setup");
        wr(0, 32'h0980_0004, 1'b1);
        wr(1, 32'h0180_0004, 1'b1);
        run(90, "R7 restart");
        wr(0, 32'h0080_0001, 1'b1);
        wr(1, 32'h0080_0001, 1'b1);
        run(60, "R7 restart to system path");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule